// File: doc/BRIEF.md
# PWM Fault Input Protection Controller

This block guards a PWM timer against external fault conditions. Four fault pins are brought into the system clock domain. Each pin can pass through a digital glitch filter and a polarity stage, and then feeds a rising-edge detector. A detected edge sets a sticky fault flag for that input. The flags are combined into a summary flag and an interrupt request. While a fault is latched, the selected PWM channel pairs are driven to fixed safe levels in place of the normal PWM values.

The PWM counter, the compare logic and the dead-time logic sit outside this block. PWM channel values arrive as plain inputs, and the block returns them either unchanged or overridden. Software clears a latched flag in two steps: it reads the flag while the flag is 1, then writes 0 to that bit.

Top module: `pwm_fault_guard`

## Requirements
- R1: Each fault pin is sampled by two flip-flops in series. A level driven before clock edge k shows on `fault_live` after edge k+1 (filter bypassed), and the flag it causes shows after edge k+2.
- R2: The filter of input n is bypassed when `filt_val` is 0 or `filt_en[n]` is 0. In that case the synchronized level feeds the polarity stage directly.
- R3: With the filter active, the filtered level follows the synchronized level only after they have differed for 4·`filt_val` consecutive clocks. Any return to equality restarts the count, so a shorter pulse has no effect.
- R4: `in_pol[n]`=1 inverts input n after the filter stage (active-low fault). `in_pol[n]`=0 keeps it active-high.
- R5: A rising edge of processed input n sets `fault_flags[n]` only when `fault_mode` is not 00 and `in_en[n]` is 1. The flag stays set until it is cleared.
- R6: `fault_any` is the OR of `fault_flags`. `fault_live` is the OR of the processed values of the inputs whose `in_en` bit is 1.
- R7: While the override is active, for every pair p with `pair_fault_en[p]`=1, `pwm_out[2p]` equals `safe_pol[2p]` and `pwm_out[2p+1]` equals `safe_pol[2p+1]`. All other channels, and every channel when the override is inactive, equal `pwm_in`.
- R8: `fault_irq` is 1 exactly when `fault_any` and `irq_en` are both 1.
- R9: A `flag_wr` pulse with bit n of `flag_wdata` at 0 clears flag n only if an earlier `flag_rd` pulse saw flag n at 1, with no write in between. It does not clear the flag when no such read happened, or when a new edge on input n arrived after the read.
- R10: The override starts on the same edge as the flag that triggers it. It stays on while any flag is set or an enabled input is live. It releases on the first edge at which neither holds, and also whenever `fault_mode` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_raw | input | 4 | Asynchronous fault pins |
| fault_mode | input | 2 | Fault handling mode; 00 disables fault control |
| in_en | input | 4 | Per-input fault enable |
| filt_en | input | 4 | Per-input filter enable |
| filt_val | input | 4 | Filter length in units of four clocks |
| in_pol | input | 4 | Per-input polarity, 1 = active-low |
| pair_fault_en | input | 4 | Per channel-pair override enable |
| safe_pol | input | 8 | Safe level for each channel |
| irq_en | input | 1 | Fault interrupt enable |
| flag_rd | input | 1 | Flag read strobe (arms the clear) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 4 | Flag write data, 0 clears an armed bit |
| pwm_in | input | 8 | Normal PWM channel values |
| pwm_out | output | 8 | PWM channel values after override |
| fault_flags | output | 4 | Sticky per-input fault flags |
| fault_any | output | 1 | OR of the fault flags |
| fault_live | output | 1 | OR of the enabled processed fault inputs |
| fault_irq | output | 1 | Fault interrupt request |

## Verification
A wrong synchronizer depth or filter count moves the cycle in which `fault_live` and the flags appear, so the error shows within a few clocks of a pin change. A broken read/write handshake shows one clock after the write, as a flag that stays set or clears when it should not. A faulty override latch shows on `pwm_out` at the edge where a flag rises or at the edge where release is due. Because every output is compared against a cycle-level model on every clock, each of these errors is reported on the first cycle it reaches a port.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    FM_OFF    = 2'b00,
    FM_EVEN   = 2'b01,
    FM_MANUAL = 2'b10,
    FM_AUTO   = 2'b11
  } fault_mode_e;

  function automatic logic mode_active(input logic [1:0] m);
    return m != FM_OFF;
  endfunction
endpackage

// File: rtl/pfg_rst_sync.sv
module pfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pfg_input_chan.sv
module pfg_input_chan #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             filt_on,
  input  logic [CNT_W-1:0] thresh,
  input  logic             pol,
  output logic             proc
);
  logic             s1_q, s2_q;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  // two-stage synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
    end
  end

  // filter next state
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!filt_on) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else if (s2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_inc >= {1'b0, thresh}) begin
      filt_d = s2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  // bypass mux, then polarity
  assign proc = (filt_on ? filt_q : s2_q) ^ pol;
endmodule

// File: rtl/pfg_flag_bank.sv
module pfg_flag_bank #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] proc,
  input  logic [NUM_IN-1:0] in_en,
  input  logic              mode_on,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [NUM_IN-1:0] wdata,
  output logic [NUM_IN-1:0] flags,
  output logic              live,
  output logic              ovr
);
  logic [NUM_IN-1:0] prev_q, flag_q, flag_d, arm_q, arm_d, set_v, clr_v;
  logic              ovr_q, ovr_d;

  assign live  = |(proc & in_en);
  assign set_v = proc & ~prev_q & in_en & {NUM_IN{mode_on}};
  assign clr_v = wr_stb ? (arm_q & ~wdata) : '0;

  always_comb begin
    flag_d = (flag_q & ~clr_v) | set_v;
    if (rd_stb)      arm_d = flag_q;
    else if (wr_stb) arm_d = '0;
    else             arm_d = arm_q;
    arm_d = arm_d & ~set_v;
    ovr_d = mode_on & ((|set_v) | (ovr_q & ((|flag_d) | live)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      arm_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      prev_q <= proc;
      flag_q <= flag_d;
      arm_q  <= arm_d;
      ovr_q  <= ovr_d;
    end
  end

  assign flags = flag_q;
  assign ovr   = ovr_q;
endmodule

// File: rtl/pfg_pair_override.sv
module pfg_pair_override #(
  parameter int NUM_PAIR = 4
) (
  input  logic                  ovr,
  input  logic [NUM_PAIR-1:0]   pair_en,
  input  logic [2*NUM_PAIR-1:0] safe_pol,
  input  logic [2*NUM_PAIR-1:0] pwm_in,
  output logic [2*NUM_PAIR-1:0] pwm_out
);
  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign pwm_out[2*p+1 -: 2] = (ovr && pair_en[p]) ? safe_pol[2*p+1 -: 2]
                                                     : pwm_in[2*p+1 -: 2];
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NUM_IN   = 4,
  parameter int NUM_PAIR = 4,
  parameter int FVAL_W   = 4,
  localparam int CNT_W   = FVAL_W + 2,
  localparam int NUM_CH  = 2 * NUM_PAIR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IN-1:0]   fault_raw,
  input  logic [1:0]          fault_mode,
  input  logic [NUM_IN-1:0]   in_en,
  input  logic [NUM_IN-1:0]   filt_en,
  input  logic [FVAL_W-1:0]   filt_val,
  input  logic [NUM_IN-1:0]   in_pol,
  input  logic [NUM_PAIR-1:0] pair_fault_en,
  input  logic [NUM_CH-1:0]   safe_pol,
  input  logic                irq_en,
  input  logic                flag_rd,
  input  logic                flag_wr,
  input  logic [NUM_IN-1:0]   flag_wdata,
  input  logic [NUM_CH-1:0]   pwm_in,
  output logic [NUM_CH-1:0]   pwm_out,
  output logic [NUM_IN-1:0]   fault_flags,
  output logic                fault_any,
  output logic                fault_live,
  output logic                fault_irq
);
  import pfg_pkg::*;

  logic              rst_sync_n;
  logic [NUM_IN-1:0] proc_v;
  logic [CNT_W-1:0]  thresh;
  logic              mode_on;
  logic              ovr_active;

  assign thresh  = {filt_val, 2'b00};
  assign mode_on = mode_active(fault_mode);

  pfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar n = 0; n < NUM_IN; n++) begin : g_in
    pfg_input_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin     (fault_raw[n]),
      .filt_on (filt_en[n] && (filt_val != '0)),
      .thresh  (thresh),
      .pol     (in_pol[n]),
      .proc    (proc_v[n])
    );
  end

  pfg_flag_bank #(.NUM_IN(NUM_IN)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .proc    (proc_v),
    .in_en   (in_en),
    .mode_on (mode_on),
    .rd_stb  (flag_rd),
    .wr_stb  (flag_wr),
    .wdata   (flag_wdata),
    .flags   (fault_flags),
    .live    (fault_live),
    .ovr     (ovr_active)
  );

  pfg_pair_override #(.NUM_PAIR(NUM_PAIR)) u_ovr (
    .ovr      (ovr_active),
    .pair_en  (pair_fault_en),
    .safe_pol (safe_pol),
    .pwm_in   (pwm_in),
    .pwm_out  (pwm_out)
  );

  assign fault_any = |fault_flags;
  assign fault_irq = fault_any & irq_en;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int NUM_IN   = 4,
  parameter int NUM_PAIR = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            fault_mode,
  input logic                  flag_wr,
  input logic                  irq_en,
  input logic [NUM_IN-1:0]     fault_flags,
  input logic                  fault_live,
  input logic                  fault_irq,
  input logic                  ovr,
  input logic [NUM_PAIR-1:0]   pair_fault_en,
  input logic [2*NUM_PAIR-1:0] safe_pol,
  input logic [2*NUM_PAIR-1:0] pwm_out
);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));

  p_no_set_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mode == 2'b00) |=> ((fault_flags & ~$past(fault_flags)) == '0));

  p_irq_needs_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> (irq_en && (fault_flags != '0)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> (((fault_flags == '0) && !$past(fault_live)) ||
                    ($past(fault_mode) == 2'b00)));

  p_no_ovr_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mode == 2'b00) |=> !ovr);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_chk
    p_safe_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && pair_fault_en[p]) |-> (pwm_out[2*p+1 -: 2] == safe_pol[2*p+1 -: 2]));
  end
endmodule

bind pwm_fault_guard pfg_checker #(.NUM_IN(NUM_IN), .NUM_PAIR(NUM_PAIR)) u_pfg_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .fault_mode    (fault_mode),
  .flag_wr       (flag_wr),
  .irq_en        (irq_en),
  .fault_flags   (fault_flags),
  .fault_live    (fault_live),
  .fault_irq     (fault_irq),
  .ovr           (ovr_active),
  .pair_fault_en (pair_fault_en),
  .safe_pol      (safe_pol),
  .pwm_out       (pwm_out)
);

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [3:0] fault_raw, in_en, filt_en, filt_val, in_pol, pair_fault_en, flag_wdata;
  logic [1:0] fault_mode;
  logic [7:0] safe_pol, pwm_in, pwm_out;
  logic       irq_en, flag_rd, flag_wr;
  logic [3:0] fault_flags;
  logic       fault_any, fault_live, fault_irq;

  int checks = 0, failures = 0;

  pwm_fault_guard i_pwm_fault_guard (
    .clk(clk), .rst_n(rst_n), .fault_raw(fault_raw), .fault_mode(fault_mode),
    .in_en(in_en), .filt_en(filt_en), .filt_val(filt_val), .in_pol(in_pol),
    .pair_fault_en(pair_fault_en), .safe_pol(safe_pol), .irq_en(irq_en),
    .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .pwm_in(pwm_in), .pwm_out(pwm_out), .fault_flags(fault_flags),
    .fault_any(fault_any), .fault_live(fault_live), .fault_irq(fault_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [3:0] m_s1, m_s2, m_filt, m_prev, m_flag, m_arm;
  logic       m_ov;
  int         m_cnt [4];

  function automatic logic [3:0] m_proc();
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      logic on;
      on   = filt_en[n] && (filt_val != 0);
      r[n] = (on ? m_filt[n] : m_s2[n]) ^ in_pol[n];
    end
    return r;
  endfunction

  function automatic logic [7:0] m_pwm();
    logic [7:0] r;
    for (int p = 0; p < 4; p++)
      r[2*p +: 2] = (m_ov && pair_fault_en[p]) ? safe_pol[2*p +: 2] : pwm_in[2*p +: 2];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_flag = 0; m_arm = 0; m_ov = 0;
      for (int n = 0; n < 4; n++) m_cnt[n] = 0;
    end else begin
      logic [3:0] pr, st, cl, nf, na;
      logic       on_m, live_now;
      pr       = m_proc();
      on_m     = fault_mode != 2'b00;
      live_now = |(pr & in_en);
      st = pr & ~m_prev & in_en & {4{on_m}};
      cl = flag_wr ? (m_arm & ~flag_wdata) : 4'b0;
      nf = (m_flag & ~cl) | st;
      na = flag_rd ? m_flag : (flag_wr ? 4'b0 : m_arm);
      na = na & ~st;
      m_ov   = on_m && ((|st) || (m_ov && ((|nf) || live_now)));
      m_prev = pr;
      m_flag = nf;
      m_arm  = na;
      for (int n = 0; n < 4; n++) begin
        if (!(filt_en[n] && filt_val != 0)) begin
          m_filt[n] = m_s2[n]; m_cnt[n] = 0;
        end else if (m_s2[n] == m_filt[n]) begin
          m_cnt[n] = 0;
        end else if (m_cnt[n] + 1 >= 4 * int'(filt_val)) begin
          m_filt[n] = m_s2[n]; m_cnt[n] = 0;
        end else begin
          m_cnt[n] = m_cnt[n] + 1;
        end
      end
      m_s2 = m_s1;
      m_s1 = fault_raw;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    check("R5 flags",   32'(fault_flags), 32'(m_flag));
    check("R6 any",     32'(fault_any),   32'(|m_flag));
    check("R6 live",    32'(fault_live),  32'(|(m_proc() & in_en)));
    check("R8 irq",     32'(fault_irq),   32'((|m_flag) & irq_en));
    check("R7 pwm",     32'(pwm_out),     32'(m_pwm()));
  endtask

  // one clock; sample at the falling edge, then strobes return low
  task automatic step();
    @(negedge clk);
    cmp_model();
    flag_rd = 1'b0;
    flag_wr = 1'b0;
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic clear_all();
    flag_rd = 1'b1; step();
    flag_wr = 1'b1; flag_wdata = 4'h0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    rst_n = 0; fault_raw = 0; fault_mode = 2'b01; in_en = 4'hF; filt_en = 0;
    filt_val = 0; in_pol = 0; pair_fault_en = 4'hF; safe_pol = 8'hA5;
    irq_en = 1; flag_rd = 0; flag_wr = 0; flag_wdata = 4'hF; pwm_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1;
    steps(5);
    // reset state
    check("R6 reset flags", 32'(fault_flags), 0);
    check("R8 reset irq",   32'(fault_irq),   0);
    check("R7 reset pwm",   32'(pwm_out),     32'h3C);

    // R1/R2: bypassed path timing
    fault_raw[0] = 1'b1;
    step();
    check("R1 live after one edge", 32'(fault_live), 0);
    step();
    check("R1 live after two edges", 32'(fault_live), 1);
    check("R1 flag not yet", 32'(fault_flags), 0);
    step();
    check("R1 flag after three edges", 32'(fault_flags), 1);
    check("R7 safe levels", 32'(pwm_out), 32'hA5);
    check("R8 irq raised", 32'(fault_irq), 1);

    // R9: write 0 without a prior read leaves the flag
    flag_wr = 1'b1; flag_wdata = 4'h0; step();
    step();
    check("R9 write without read", 32'(fault_flags), 1);
    // read then write clears, but input still live keeps override (R10)
    clear_all(); step();
    check("R9 read then write clears", 32'(fault_flags), 0);
    check("R10 held while live", 32'(pwm_out), 32'hA5);
    fault_raw[0] = 1'b0;
    steps(2);
    check("R10 live gone", 32'(fault_live), 0);
    step();
    check("R10 released", 32'(pwm_out), 32'h3C);

    // R9: new edge after read cancels the clear
    fault_raw[3] = 1'b1; steps(4);
    flag_rd = 1'b1; step();
    fault_raw[3] = 1'b0; steps(3);
    fault_raw[3] = 1'b1; steps(3);
    flag_wr = 1'b1; flag_wdata = 4'h0; step();
    step();
    check("R9 edge after read keeps flag", 32'(fault_flags[3]), 1);
    fault_raw[3] = 1'b0; steps(3);
    clear_all(); steps(2);

    // R4: inverting the idle-low input creates an active level
    in_pol[1] = 1'b1; step();
    check("R4 active-low sets flag", 32'(fault_flags[1]), 1);
    in_pol[1] = 1'b0; clear_all(); steps(3);

    // R3: filter of 2 -> 8 clocks
    filt_val = 4'd2; filt_en = 4'b0100; irq_en = 1'b0;
    fault_raw[2] = 1'b1; steps(7);
    fault_raw[2] = 1'b0; steps(12);
    check("R3 short pulse rejected", 32'(fault_flags[2]), 0);
    fault_raw[2] = 1'b1; steps(10);
    check("R3 flag not before count", 32'(fault_flags[2]), 0);
    step();
    check("R3 flag after full count", 32'(fault_flags[2]), 1);
    check("R8 irq masked", 32'(fault_irq), 0);
    fault_raw[2] = 1'b0; steps(12);
    clear_all(); filt_en = 0; irq_en = 1; steps(2);

    // R5: mode off and disabled input do not set flags
    fault_mode = 2'b00; fault_raw[1] = 1'b1; steps(4);
    check("R5 mode off no flag", 32'(fault_flags), 0);
    fault_raw[1] = 1'b0; fault_mode = 2'b10; in_en = 4'b1101; steps(3);
    fault_raw[1] = 1'b1; steps(4);
    check("R5 disabled input no flag", 32'(fault_flags), 0);
    check("R6 disabled input not live", 32'(fault_live), 0);
    fault_raw[1] = 1'b0; in_en = 4'hF; steps(3);

    // R7: only enabled pairs are forced
    pair_fault_en = 4'b0010; safe_pol = 8'h00; pwm_in = 8'hFF;
    fault_raw[0] = 1'b1; steps(3);
    check("R7 partial pairs", 32'(pwm_out), 32'hF3);
    fault_raw[0] = 1'b0; steps(3); clear_all(); steps(2);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(7) == 0) fault_raw[$urandom_range(3)] ^= 1'b1;
      if ($urandom_range(59) == 0) begin
        fault_mode = 2'($urandom); in_en = 4'($urandom); filt_en = 4'($urandom);
        filt_val = 4'($urandom_range(3)); in_pol = 4'($urandom);
        pair_fault_en = 4'($urandom); safe_pol = 8'($urandom);
        irq_en = 1'($urandom);
      end
      pwm_in = 8'($urandom);
      flag_rd = ($urandom_range(9) == 0);
      flag_wr = ($urandom_range(9) == 0);
      flag_wdata = 4'($urandom);
      @(negedge clk);
      cmp_model();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule